// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block turns register settings into several independent pulse-width-modulated outputs. Each channel owns a prescaler whose divide ratio is a power of two, a period counter and a threshold compare. A channel's output goes high at the start of every period and stays high for the programmed number of divided ticks, then drops low for the rest of the period.

Period and high-time registers both hold "length minus one". A period register value W gives W+1 divided ticks per period, and a threshold value T gives T+1 ticks high. A zero duty cycle is made by clearing the channel's bit in the shared enable register, which forces the output low. A single-cycle word-addressed write/read port programs every register. Writes to a running channel's settings wait for the end of the current period.

Top module: `prescaled_pwm`

## Requirements
- R1: During and right after reset every register reads zero and every output is low.
- R2: Register map. Address 0 is the enable register, with channel c at bit c. Channel c uses word addresses 4+4c (control), 5+4c (period W, bits 12:0) and 6+4c (threshold T, bits 12:0). Control holds the divide exponent D in bits 2:0 and a stored mode flag in bit 15. Every register reads back the last value written, masked to its fields. All other bits and all unmapped addresses read zero.
- R3: An enabled channel has a period of (W+1)<<D clock cycles.
- R4: When T<W, the output is high for the first (T+1)<<D cycles of each period.
- R5: When T>=W, the output stays high for the whole period.
- R6: While a channel's enable bit is clear, its output is low. This starts in the cycle after the write that clears the bit.
- R7: Setting an enable bit restarts the channel from count zero. The output is high in the first cycle after the write.
- R8: Writes to the control, period or threshold register of a running channel leave the current period unchanged. They take effect from the next period boundary.
- R9: Channels run independently, and enabling one leaves the others low.
- R10: The control mode flag has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W (5) | Word address for reads and writes |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, same cycle |
| pwm_o | output | NUM_CH (4) | One PWM output per channel |

## Verification
The bench builds the block with its defaults: four channels, 13-bit counters and a 3-bit divide exponent. With four channels it can run two channels at once while two others stay idle, and it can place control registers at nonzero channel offsets. Short periods and exponents up to 2 keep whole waveforms within windows of a few dozen cycles. The 13-bit period width is covered through masking on readback, not by running an 8192-tick period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int EN_ADDR  = 0;
  localparam int MODE_BIT = 15;
  localparam int FIRST_CH_SLOT = 1;  // channel c occupies word slot c+1 (addresses 4c+4..)

  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_WIDTH = 2'd1,
    FLD_THRES = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 13,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0]             en_o,
  output logic [NUM_CH-1:0][DIV_W-1:0]  div_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  width_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  thres_o
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [NUM_CH-1:0] mode_v;
  logic [SLOT_W-1:0] slot;
  fld_e              fld;

  assign slot = addr_i[ADDR_W-1:2];
  assign fld  = fld_e'(addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= '0;
    end else if (we_i && addr_i == ADDR_W'(EN_ADDR)) begin
      en_o <= wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(FIRST_CH_SLOT + c);
    logic             hit;
    logic [DIV_W-1:0] div_q;
    logic             mode_q;
    logic [CNT_W-1:0] wid_q;
    logic [CNT_W-1:0] thr_q;

    assign hit = we_i && (slot == MY_SLOT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q  <= '0;
        mode_q <= 1'b0;
        wid_q  <= '0;
        thr_q  <= '0;
      end else if (hit) begin
        unique case (fld)
          FLD_CTRL: begin
            div_q  <= wdata_i[DIV_W-1:0];
            mode_q <= wdata_i[MODE_BIT];
          end
          FLD_WIDTH: wid_q <= wdata_i[CNT_W-1:0];
          FLD_THRES: thr_q <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    assign div_o[c]   = div_q;
    assign mode_v[c]  = mode_q;
    assign width_o[c] = wid_q;
    assign thres_o[c] = thr_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(EN_ADDR)) begin
      rdata_o[NUM_CH-1:0] = en_o;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot == SLOT_W'(FIRST_CH_SLOT + c)) begin
        case (fld)
          FLD_CTRL: begin
            rdata_o[DIV_W-1:0] = div_o[c];
            rdata_o[MODE_BIT]  = mode_v[c];
          end
          FLD_WIDTH: rdata_o[CNT_W-1:0] = width_o[c];
          FLD_THRES: rdata_o[CNT_W-1:0] = thres_o[c];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  assign mask   = (PRE_W'(1) << div_i) - PRE_W'(1);
  assign tick_o = (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 13,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] thres_i,
  output logic             pwm_o
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] thres_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             wrap;

  pwm_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign wrap = tick && (cnt_q == width_q);

  // shadows follow live settings while idle, and only at wrap while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      width_q <= '0;
      thres_q <= '0;
      cnt_q   <= '0;
    end else if (!en_i || wrap) begin
      div_q   <= div_i;
      width_q <= width_i;
      thres_q <= thres_i;
      cnt_q   <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign pwm_o = en_i && (cnt_q <= thres_q);
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 13,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0]            en;
  logic [NUM_CH-1:0][DIV_W-1:0] div;
  logic [NUM_CH-1:0][CNT_W-1:0] width;
  logic [NUM_CH-1:0][CNT_W-1:0] thres;

  pwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .div_o   (div),
    .width_o (width),
    .thres_o (thres)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[c]),
      .div_i   (div[c]),
      .width_i (width[c]),
      .thres_i (thres[c]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: rtl/prescaled_pwm_chk.sv
module prescaled_pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] pwm_o
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> pwm_o == '0);

  // R6
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~en_q) == '0);

  // R2
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> en_q == $past(wdata_i[NUM_CH-1:0]));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    restart_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q[c]) |-> pwm_o[c]);
  end
endmodule

bind prescaled_pwm prescaled_pwm_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_q    (en),
  .pwm_o   (pwm_o)
);

// File: tb/tb_prescaled_pwm.sv
module tb_prescaled_pwm;
  localparam int CLK_P = 10;
  localparam int NCH = 4;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] pwm;

  int n_chk = 0;
  int n_err = 0;
  logic [NCH-1:0] samp [0:255];
  logic           expb [0:255];

  prescaled_pwm dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [AW-1:0] a_ctrl(int c); return AW'(4 + 4*c); endfunction
  function automatic logic [AW-1:0] a_wid(int c);  return AW'(5 + 4*c); endfunction
  function automatic logic [AW-1:0] a_thr(int c);  return AW'(6 + 4*c); endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    addr = a; #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic capture(input int n);
    for (int k = 0; k < n; k++) begin
      samp[k] = pwm;
      @(negedge clk);
    end
  endtask

  function automatic void fill_exp(int n, int w, int t, int d);
    for (int k = 0; k < n; k++) expb[k] = (((k >> d) % (w + 1)) <= t);
  endfunction

  task automatic cmp_pat(input int ch, input int n, input string req);
    int bad = -1;
    for (int k = 0; k < n; k++)
      if (bad < 0 && samp[k][ch] !== expb[k]) bad = k;
    chk(bad < 0, req, (bad < 0) ? 0 : {bad, 4'h0, 3'b0, samp[bad][ch]},
        (bad < 0) ? 0 : {bad, 4'h0, 3'b0, expb[bad]});
  endtask

  task automatic t_reset;
    chk(pwm == '0, "R1 outputs", pwm, 0);
    rd_chk(AW'(0), 0, "R1 enable");
    rd_chk(a_ctrl(2), 0, "R1 ctrl");
    rd_chk(a_wid(0), 0, "R1 width");
    rd_chk(a_thr(3), 0, "R1 thres");
  endtask

  task automatic t_readback;
    wr(a_ctrl(1), 32'hF0F0_8005);
    wr(a_wid(1), 32'h0000_FFFF);
    wr(a_thr(3), 32'h0000_1234);
    rd_chk(a_ctrl(1), 32'h0000_8005, "R2 ctrl");
    rd_chk(a_wid(1), 32'h0000_1FFF, "R2 width mask");
    rd_chk(a_thr(3), 32'h0000_1234, "R2 thres");
    rd_chk(a_ctrl(3), 0, "R2 other ctrl");
    wr(AW'(0), 32'h0000_00FA);
    rd_chk(AW'(0), 32'h0000_000A, "R2 enable");
    wr(AW'(0), 0);
    rd_chk(AW'(3), 0, "R2 unmapped 3");
    rd_chk(AW'(7), 0, "R2 unmapped 7");
    wr(a_ctrl(1), 0); wr(a_wid(1), 0); wr(a_thr(3), 0);
  endtask

  task automatic t_basic;  // R3 R4 R6
    wr(a_ctrl(0), 0); wr(a_wid(0), 4); wr(a_thr(0), 1);
    wr(AW'(0), 32'h1);
    capture(15);
    fill_exp(15, 4, 1, 0);
    cmp_pat(0, 15, "R3/R4 div1 w4 t1");
    wr(AW'(0), 0);
    capture(10);
    for (int k = 0; k < 10; k++) expb[k] = 1'b0;
    cmp_pat(0, 10, "R6 disabled low");
  endtask

  task automatic t_prescale;  // R3 R4 R10
    wr(a_ctrl(2), 32'h0000_8002); wr(a_wid(2), 3); wr(a_thr(2), 0);
    wr(AW'(0), 32'h4);
    capture(48);
    fill_exp(48, 3, 0, 2);
    cmp_pat(2, 48, "R3/R4/R10 div4 w3 t0 mode set");
    wr(AW'(0), 0);
  endtask

  task automatic t_full;  // R5
    wr(a_ctrl(3), 1); wr(a_wid(3), 2); wr(a_thr(3), 5);
    wr(AW'(0), 32'h8);
    capture(20);
    for (int k = 0; k < 20; k++) expb[k] = 1'b1;
    cmp_pat(3, 20, "R5 thres>=width");
    wr(AW'(0), 0);
  endtask

  task automatic t_update;  // R8
    wr(a_ctrl(1), 0); wr(a_wid(1), 9); wr(a_thr(1), 4);
    wr(AW'(0), 32'h2);
    fork
      capture(25);
      begin wr(a_wid(1), 2); wr(a_thr(1), 0); end
    join
    for (int k = 0; k < 25; k++)
      expb[k] = (k < 10) ? (k <= 4) : (((k - 10) % 3) == 0);
    cmp_pat(1, 25, "R8 boundary update");
    wr(AW'(0), 0);
  endtask

  task automatic t_multi;  // R9
    wr(a_ctrl(0), 0); wr(a_wid(0), 1); wr(a_thr(0), 0);
    wr(a_ctrl(2), 1); wr(a_wid(2), 4); wr(a_thr(2), 2);
    wr(AW'(0), 32'h5);
    capture(30);
    fill_exp(30, 1, 0, 0);
    cmp_pat(0, 30, "R9 ch0");
    fill_exp(30, 4, 2, 1);
    cmp_pat(2, 30, "R9 ch2");
    for (int k = 0; k < 30; k++) expb[k] = 1'b0;
    cmp_pat(1, 30, "R9 ch1 idle");
    cmp_pat(3, 30, "R9 ch3 idle");
    wr(AW'(0), 0);
  endtask

  task automatic t_restart;  // R7
    wr(a_ctrl(0), 0); wr(a_wid(0), 7); wr(a_thr(0), 3);
    wr(AW'(0), 32'h1);
    repeat (5) @(negedge clk);
    wr(AW'(0), 0);
    wr(AW'(0), 32'h1);
    capture(16);
    fill_exp(16, 7, 3, 0);
    cmp_pat(0, 16, "R7 restart from zero");
    wr(AW'(0), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_readback;
    t_basic;
    t_prescale;
    t_full;
    t_update;
    t_multi;
    t_restart;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule